// File: doc/BRIEF.md
# Chained One-Hot Decade Sequencer

This block links several ten-position one-hot counter stages into one long running-light sequence. A single-cycle step strobe, sampled on the system clock, moves the lit position forward. Control passes from stage to stage through the stages' own end positions. A stage that reaches its last position, Q9, freezes there and lets the next stage take steps. While a stage sits at its first position, Q0, it holds the following stage cleared. When the last stage reaches Q9, it clears the first stage, and the sequence starts over.

Q9 of every stage is used only for hand-off and is never a user position. Q0 of every stage except the first is also not a user position. With N stages (N at least two), one loop therefore shows 9 + 8·(N−1) user positions: 25 for the default of three stages. A per-stage advance flag shows which stage moves at the next clock edge.

Stage k occupies bits [10k+9:10k] of `state_o`, and bit j of that field is position Qj. The step from Q9 of the last stage back to the starting state takes N cycles. It clears stage 0 first, and the clear then ripples one stage per cycle.

Top module: `decade_chain`

## Requirements
- R1: While `rst_ni` is low, and for two clock cycles after it is released, every stage holds Q0 (bit 0 of its field set) and strobes are ignored.
- R2: Each stage's 10-bit field has exactly one bit set in every cycle.
- R3: Stage 0 moves from Qj to Qj+1 at the edge after a cycle in which `step_i` is high, provided it is not at Q9 and not being cleared. With `step_i` low, no stage advances.
- R4: A stage at Q9 stays at Q9 whatever the strobe does, until it is cleared.
- R5: Stage k>0 advances on a strobe only if stage k−1 is at Q9, or is moving from Q8 into Q9 on that same strobe. In the second case both stages move at the same edge.
- R6: For k>0, if stage k−1 is at Q0 in a cycle, stage k is at Q0 in the next cycle.
- R7: If the last stage is at Q9 in a cycle, stage 0 is at Q0 in the next cycle. Stage 0 ignores strobes for as long as the last stage sits at Q9, so the return to the starting state takes N cycles.
- R8: `adv_o[k]` is high in exactly the cycles after which stage k moves up one position.
- R9: At most one user position (stage 0 at Q0..Q8, or stage k>0 at Q1..Q8) is lit at a time. Numbered along the chain, these positions appear in strict order 0..9+8·(N−1)−1 and then repeat from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| step_i | input | 1 | Single-cycle step strobe |
| state_o | output | 10·NUM_STAGES | Concatenated one-hot stage states, stage k at [10k+9:10k] |
| adv_o | output | NUM_STAGES | Stage k moves up one position at the next edge |

## Verification
The bench targets the same-strobe hand-off. A design that waited for the predecessor's registered Q9 would show an extra blank step at every stage boundary. It also targets the wrap, where strobes arriving while the last stage sits at Q9 must be lost. A design that let stage 0 count during the clear would skip positions. Strobes every cycle, sparse strobes and pseudo-random strobes are all compared against a behavioural model, so a stage that leaves Q9 early, or a clear that ripples in the wrong direction, breaks the position order or the loop length of 9+8·(N−1).

// File: rtl/decade_chain_pkg.sv
package decade_chain_pkg;
  localparam int unsigned STAGE_W = 10;
  localparam int unsigned LAST    = STAGE_W - 1;
  typedef logic [STAGE_W-1:0] onehot_t;
endpackage

// File: rtl/decade_rst_sync.sv
module decade_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[DEPTH-1];
endmodule

// File: rtl/decade_stage.sv
module decade_stage
  import decade_chain_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    step_i,
  input  logic    clr_i,
  output onehot_t q_o,
  output logic    adv_o
);
  onehot_t q_q;
  onehot_t q_d;
  logic    step_ok;
  logic    load_en;

  // own Q9 inhibits stepping; chain clear has priority
  assign step_ok = step_i & ~q_q[LAST] & ~clr_i;
  assign load_en = clr_i | step_ok;

  always_comb begin
    q_d = q_q;
    if (clr_i)        q_d = onehot_t'(1);
    else if (step_ok) q_d = {q_q[LAST-1:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= onehot_t'(1);
    else if (load_en) q_q <= q_d;
  end

  assign q_o   = q_q;
  assign adv_o = step_ok;
endmodule

// File: rtl/decade_chain.sv
module decade_chain
  import decade_chain_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          step_i,
  output logic [NUM_STAGES*STAGE_W-1:0] state_o,
  output logic [NUM_STAGES-1:0]         adv_o
);
  localparam int unsigned TAIL = NUM_STAGES - 1;

  logic                  run_n;
  logic                  step_q;
  logic [NUM_STAGES-1:0] stage_en;
  logic [NUM_STAGES-1:0] stage_clr;
  logic [NUM_STAGES-1:0] stage_adv;
  logic [NUM_STAGES-1:0] pass_on;
  onehot_t               stage_q [NUM_STAGES];

  decade_rst_sync #(.DEPTH(2)) u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(run_n)
  );

  assign step_q = step_i & run_n;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign stage_en[k]  = step_q;
      assign stage_clr[k] = stage_q[TAIL][LAST];
    end else begin : g_body
      assign stage_en[k]  = step_q & pass_on[k-1];
      assign stage_clr[k] = stage_q[k-1][0];
    end

    // hand-off: at Q9 already, or entering Q9 on this very strobe
    assign pass_on[k] = stage_q[k][LAST] | (stage_adv[k] & stage_q[k][LAST-1]);

    decade_stage u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .step_i(stage_en[k]),
      .clr_i (stage_clr[k]),
      .q_o   (stage_q[k]),
      .adv_o (stage_adv[k])
    );

    assign state_o[k*STAGE_W +: STAGE_W] = stage_q[k];
  end

  assign adv_o = stage_adv;
endmodule

// File: rtl/decade_chain_chk.sv
module decade_chain_chk #(
  parameter int unsigned NUM_STAGES = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     step_i,
  input logic [NUM_STAGES*10-1:0] state_o,
  input logic [NUM_STAGES-1:0]    adv_o
);
  localparam int unsigned TOP = NUM_STAGES*10 - 1;

  a_r3_no_strobe_no_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |-> (adv_o == '0));

  a_r7_wrap_clears_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o[TOP] |=> state_o[0]);

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_chk
    a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(state_o[k*10 +: 10]) == 1);

    a_r8_adv_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adv_o[k] |=> (state_o[k*10 +: 10] == ($past(state_o[k*10 +: 10]) << 1)));

    if (k == 0) begin : g_h
      a_r4_q9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o[9] && !state_o[TOP]) |=> state_o[9]);
    end else begin : g_b
      a_r4_q9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o[k*10+9] && !state_o[(k-1)*10]) |=> state_o[k*10+9]);

      a_r6_chain_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o[(k-1)*10] |=> state_o[k*10]);

      a_r5_gated_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_o[k] |-> (state_o[(k-1)*10+9] || (adv_o[k-1] && state_o[(k-1)*10+8])));
    end
  end
endmodule

bind decade_chain decade_chain_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .step_i (step_i),
  .state_o(state_o),
  .adv_o  (adv_o)
);

// File: tb/decade_chain_tb_top.sv
module decade_chain_tb_top;
  localparam int N = 3;
  localparam int L = 9 + 8*(N-1);

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            step_i = 1'b0;
  logic [N*10-1:0] state_o;
  logic [N-1:0]    adv_o;

  int total = 0;
  int bad = 0;
  int pos [N];
  int rel_cnt = 0;
  int last_idx = -1;
  int seen = 0;
  int loops = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk_i = ~clk_i;

  decade_chain #(.NUM_STAGES(N)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i),
    .state_o(state_o), .adv_o(adv_o)
  );

  function automatic logic [N*10-1:0] exp_vec();
    logic [N*10-1:0] v = '0;
    for (int k = 0; k < N; k++) v[k*10 + pos[k]] = 1'b1;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic track_visible();
    int vis = 0;
    int idx = -1;
    for (int k = 0; k < N; k++) begin
      for (int j = 0; j < 10; j++) begin
        if (state_o[k*10+j]) begin
          if (k == 0 && j <= 8) begin vis++; idx = j; end
          else if (k > 0 && j >= 1 && j <= 8) begin vis++; idx = 9 + 8*(k-1) + j - 1; end
        end
      end
    end
    check(vis <= 1, "R9 visible count", vis, 1);
    if (vis == 1 && idx != last_idx) begin
      check(idx == ((last_idx < 0) ? 0 : (last_idx + 1) % L), "R9 order", idx, (last_idx + 1) % L);
      if (idx == 0 && last_idx == L-1) begin
        check(seen == L, "R9 loop length", seen, L);
        loops++;
        seen = 1;
      end else begin
        seen++;
      end
      last_idx = idx;
    end
  endtask

  // one cycle: compare at negedge, drive inputs, check flags, advance model
  task automatic cyc(input bit rst_v, input bit stp);
    bit pass_on;
    bit clr;
    bit go;
    int npos [N];
    @(negedge clk_i);
    check(state_o == exp_vec(), "R3 R4 R5 R6 R7 state", state_o, exp_vec());
    for (int k = 0; k < N; k++)
      check($countones(state_o[k*10 +: 10]) == 1, "R2 onehot", state_o[k*10 +: 10], 0);
    if (rst_ni) track_visible();
    rst_ni = rst_v;
    step_i = stp;
    #1;
    if (!rst_v) begin
      for (int k = 0; k < N; k++) pos[k] = 0;
      rel_cnt = 0;
      last_idx = -1;
      seen = 0;
      check(state_o == exp_vec(), "R1 reset state", state_o, exp_vec());
      check(adv_o == '0, "R1 no advance in reset", adv_o, 0);
    end else begin
      pass_on = 1'b1;
      for (int k = 0; k < N; k++) begin
        clr = (k == 0) ? (pos[N-1] == 9) : (pos[k-1] == 0);
        go  = stp && (rel_cnt >= 2) && pass_on && (pos[k] != 9) && !clr;
        check(adv_o[k] == go, "R8 advance flag", adv_o[k], go);
        npos[k] = clr ? 0 : (go ? pos[k] + 1 : pos[k]);
        pass_on = (pos[k] == 9) || (go && pos[k] == 8);
      end
      for (int k = 0; k < N; k++) pos[k] = npos[k];
      rel_cnt++;
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) pos[k] = 0;
    // R1: reset, then strobes in the two release cycles must be ignored
    repeat (4) cyc(1'b0, 1'b1);
    cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b1);
    repeat (3) cyc(1'b1, 1'b0);
    // R3 R5 R7: strobe every cycle, several loops, strobes during wrap
    repeat (4 * (L + N + 2)) cyc(1'b1, 1'b1);
    // R3 R4: idle, nothing may move
    repeat (6) cyc(1'b1, 1'b0);
    // sparse strobes
    for (int i = 0; i < 3 * 3 * (L + N); i++) cyc(1'b1, (i % 3) == 0);
    // pseudo-random strobes
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(1'b1, lfsr[0]);
    end
    // R1: reset in mid-run, then run again
    repeat (2) cyc(1'b0, 1'b0);
    repeat (3 * (L + N + 2)) cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b0);
    check(loops >= 4, "R9 loops completed", loops, 4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule